// File: doc/BRIEF.md
# CSR Access Unit with 64-bit Counters

This block carries out control/status register instructions against a small register file. The file holds three 64-bit counters, each read as a low and a high 32-bit half, and one 32-bit scratch register. The cycle counter advances on every clock, the time counter advances on an external tick, and the retired-instruction counter advances on a retire pulse. The scratch register writes only the bits that a parameter mask allows. The retired-instruction counter can also be written, through a second pair of addresses.

The pipeline presents one decoded instruction per cycle: the opcode, funct3, the rd and rs1 register fields, the 12-bit CSR address and the rs1 register value, together with a valid strobe. The unit answers in the same cycle with the zero-extended old CSR value and three flags that say whether a read took place, whether a write took place, and whether the access was illegal. State changes at the next clock edge. The unit follows the architectural rules that suppress a read or a write. It also orders a counter write after the same instruction's own retire increment.

Top module: `csr_unit`

## Requirements
- R1: An instruction is acted on only when valid is high, the opcode is 1110011 and funct3 is one of 001 (swap), 010 (set), 011 (clear), 101 (swap immediate), 110 (set immediate) or 111 (clear immediate). The immediate forms use the 5-bit rs1 field, zero-extended, as the source value and ignore the rs1 register value. Any other opcode or funct3 leaves every output at zero and changes no state.
- R2: When a read is performed, rd_value carries the CSR contents from before the instruction, zero-extended to 32 bits, in the same cycle as valid. Any write lands at the following clock edge.
- R3: The swap forms with rd field 0 perform no read: read_done is 0 and rd_value is 0. The write still happens.
- R4: The set and clear forms with rs1 field 0 (register or immediate) perform no write, so write_done is 0. A set or clear whose rs1 field is nonzero writes even when the source value is zero.
- R5: Set changes only the bits that are high in the source, and clear changes only those bits. In the scratch register (address 0x340) only bits in the parameter mask (default 0xFFFF00FF) are writable. The other bits keep their reset value 0.
- R6: The counter address map is as follows. Cycle, time and retired-instruction counter low halves are at 0xC00, 0xC01 and 0xC02. Their high halves are at 0xC80, 0xC81 and 0xC82. The retired-instruction counter is writable through 0xB02 (low half) and 0xB82 (high half).
- R7: All counters reset to zero. Cycle increments every clock, time increments on each clock where timer_tick is high, and the retired-instruction counter increments on each clock where retire is high, with carry from the low half into the high half.
- R8: A write to the retired-instruction counter takes effect after that same cycle's retire increment. The following instruction reads exactly the written half, and the unwritten half reflects the increment.
- R9: A write that is actually performed on a read-only address (0xC00–0xC02, 0xC80–0xC82) raises illegal. A read-only access that performs no write is legal.
- R10: Any address outside the map raises illegal. Whenever illegal is high, read_done, write_done and rd_value are 0 and no state changes.
- R11: After reset, with valid low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | Instruction present this cycle |
| inst_opcode | input | 7 | Major opcode field |
| inst_funct3 | input | 3 | Minor operation field |
| inst_rd | input | 5 | Destination register index |
| inst_rs1 | input | 5 | Source register index or 5-bit immediate |
| inst_csr | input | 12 | CSR address |
| rs1_value | input | 32 | Contents of the source register |
| retire | input | 1 | An instruction retires this cycle |
| timer_tick | input | 1 | Real-time tick |
| rd_value | output | 32 | Old CSR value for the destination register |
| read_done | output | 1 | A CSR read was performed |
| write_done | output | 1 | A CSR write was performed |
| illegal | output | 1 | Illegal CSR access |

## Verification
The scratch register is driven with swap, set and clear in both source forms. The sources are all-ones, partial patterns that straddle the read-only bit field, and zero. These runs separate correct mask merging from a plain overwrite, and register sourcing from immediate sourcing. Zero-index and zero-value sources are compared against each other to show that only the field index suppresses a write. Retired-instruction counter writes are issued on cycles that also carry a retire pulse, and a low-half overflow is forced. These runs tell the correct increment-then-write order apart from the reverse order, and confirm the carry. The read-only counters are accessed both with suppressed and with performed writes, which shows that illegal depends on an actual write.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

    localparam int XLEN    = 32;
    localparam int CNT_W   = 2 * XLEN;
    localparam int NUM_CNT = 3;
    localparam int IDX_W   = $clog2(NUM_CNT);

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    // counter indices
    localparam int CNT_CYCLE   = 0;
    localparam int CNT_TIME    = 1;
    localparam int CNT_INSTRET = 2;

    // address map
    localparam logic [11:0] ADR_RO_LO_BASE = 12'hC00;
    localparam logic [11:0] ADR_RO_HI_BASE = 12'hC80;
    localparam logic [11:0] ADR_RW_LO_BASE = 12'hB00;
    localparam logic [11:0] ADR_RW_HI_BASE = 12'hB80;
    localparam logic [11:0] ADR_SCRATCH    = 12'h340;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SWAP = 2'b01,
        ACT_SET  = 2'b10,
        ACT_CLR  = 2'b11
    } csr_act_e;

    typedef struct packed {
        logic            hit;
        csr_act_e        act;
        logic            rd_intent;
        logic            wr_intent;
        logic [XLEN-1:0] src;
    } csr_req_t;

    typedef struct packed {
        logic             mapped;
        logic             ro;
        logic             is_cnt;
        logic             is_scr;
        logic             hi_half;
        logic [IDX_W-1:0] cnt_idx;
    } csr_sel_t;

    function automatic logic [XLEN-1:0] csr_merge(
        input csr_act_e        act,
        input logic [XLEN-1:0] old_val,
        input logic [XLEN-1:0] src
    );
        logic [XLEN-1:0] res;
        case (act)
            ACT_SWAP: res = src;
            ACT_SET:  res = old_val | src;
            ACT_CLR:  res = old_val & ~src;
            default:  res = old_val;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_unit_pkg::*;
(
    input  logic            valid,
    input  logic [6:0]      opcode,
    input  logic [2:0]      funct3,
    input  logic [4:0]      rd,
    input  logic [4:0]      rs1,
    input  logic [XLEN-1:0] rs1_value,
    output csr_req_t        req
);
    logic use_imm;
    logic rs1_zero;

    assign use_imm  = funct3[2];
    assign rs1_zero = (rs1 == 5'd0);

    always_comb begin
        req     = '0;
        req.act = csr_act_e'(funct3[1:0]);
        req.src = use_imm ? {{(XLEN-5){1'b0}}, rs1} : rs1_value;
        req.hit = valid && (opcode == OPC_SYSTEM) && (funct3[1:0] != 2'b00);
        if (req.act == ACT_SWAP) begin
            req.rd_intent = (rd != 5'd0);
            req.wr_intent = 1'b1;
        end else begin
            req.rd_intent = 1'b1;
            req.wr_intent = !rs1_zero;
        end
        if (!req.hit) begin
            req.rd_intent = 1'b0;
            req.wr_intent = 1'b0;
        end
    end

endmodule

// File: rtl/csr_addr_map.sv
module csr_addr_map
    import csr_unit_pkg::*;
#(
    parameter logic [NUM_CNT-1:0] CNT_WRITABLE = 3'b100
) (
    input  logic [11:0] addr,
    output csr_sel_t    sel
);
    always_comb begin
        sel = '0;
        if (addr == ADR_SCRATCH) begin
            sel.mapped = 1'b1;
            sel.is_scr = 1'b1;
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (addr == ADR_RO_LO_BASE + 12'(i) || addr == ADR_RO_HI_BASE + 12'(i)) begin
                sel.mapped  = 1'b1;
                sel.ro      = 1'b1;
                sel.is_cnt  = 1'b1;
                sel.hi_half = (addr == ADR_RO_HI_BASE + 12'(i));
                sel.cnt_idx = IDX_W'(i);
            end
            if (CNT_WRITABLE[i] &&
                (addr == ADR_RW_LO_BASE + 12'(i) || addr == ADR_RW_HI_BASE + 12'(i))) begin
                sel.mapped  = 1'b1;
                sel.ro      = 1'b0;
                sel.is_cnt  = 1'b1;
                sel.hi_half = (addr == ADR_RW_HI_BASE + 12'(i));
                sel.cnt_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/csr_counter64.sv
module csr_counter64
    import csr_unit_pkg::*;
#(
    parameter bit WRITABLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [XLEN-1:0]  wdata,
    output logic [CNT_W-1:0] value
);
    logic [CNT_W-1:0] stepped;
    logic [CNT_W-1:0] nxt;

    // increment first, then overlay the written half
    always_comb begin
        stepped = value + CNT_W'(inc);
        nxt     = stepped;
        if (WRITABLE && wr_lo) nxt[XLEN-1:0]     = wdata;
        if (WRITABLE && wr_hi) nxt[CNT_W-1:XLEN] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) value <= '0;
        else     value <= nxt;
    end

endmodule

// File: rtl/csr_scratch.sv
module csr_scratch
    import csr_unit_pkg::*;
#(
    parameter logic [XLEN-1:0] WMASK = 32'hFFFF_00FF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)     value <= '0;
        else if (wr) value <= (value & ~WMASK) | (wdata & WMASK);
    end

endmodule

// File: rtl/csr_unit.sv
module csr_unit
    import csr_unit_pkg::*;
#(
    parameter logic [XLEN-1:0]    SCRATCH_WMASK = 32'hFFFF_00FF,
    parameter logic [NUM_CNT-1:0] CNT_WRITABLE  = 3'b100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        inst_valid,
    input  logic [6:0]  inst_opcode,
    input  logic [2:0]  inst_funct3,
    input  logic [4:0]  inst_rd,
    input  logic [4:0]  inst_rs1,
    input  logic [11:0] inst_csr,
    input  logic [31:0] rs1_value,
    input  logic        retire,
    input  logic        timer_tick,
    output logic [31:0] rd_value,
    output logic        read_done,
    output logic        write_done,
    output logic        illegal
);
    csr_req_t         req;
    csr_sel_t         sel;
    logic [CNT_W-1:0] cnt_q   [NUM_CNT];
    logic [NUM_CNT-1:0] cnt_inc;
    logic [XLEN-1:0]  scr_q;
    logic [XLEN-1:0]  old_val;
    logic [XLEN-1:0]  new_val;
    logic             wr_fire;
    logic             rd_fire;
    logic             bad;
    logic [CNT_W-1:0] cycle_q;
    logic [CNT_W-1:0] time_q;
    logic [CNT_W-1:0] instret_q;

    csr_decode u_dec (
        .valid     (inst_valid),
        .opcode    (inst_opcode),
        .funct3    (inst_funct3),
        .rd        (inst_rd),
        .rs1       (inst_rs1),
        .rs1_value (rs1_value),
        .req       (req)
    );

    csr_addr_map #(.CNT_WRITABLE(CNT_WRITABLE)) u_map (
        .addr (inst_csr),
        .sel  (sel)
    );

    assign cnt_inc = {retire, timer_tick, 1'b1};

    always_comb begin
        if (sel.is_scr)       old_val = scr_q;
        else if (sel.hi_half) old_val = cnt_q[sel.cnt_idx][CNT_W-1:XLEN];
        else                  old_val = cnt_q[sel.cnt_idx][XLEN-1:0];
    end

    assign new_val = csr_merge(req.act, old_val, req.src);

    assign bad     = req.hit && (!sel.mapped || (req.wr_intent && sel.ro));
    assign wr_fire = req.hit && req.wr_intent && !bad;
    assign rd_fire = req.hit && req.rd_intent && !bad;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
            logic sel_me;
            assign sel_me = wr_fire && sel.is_cnt && (sel.cnt_idx == IDX_W'(gi));
            csr_counter64 #(.WRITABLE(CNT_WRITABLE[gi])) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .inc   (cnt_inc[gi]),
                .wr_lo (sel_me && !sel.hi_half),
                .wr_hi (sel_me && sel.hi_half),
                .wdata (new_val),
                .value (cnt_q[gi])
            );
        end
    endgenerate

    csr_scratch #(.WMASK(SCRATCH_WMASK)) u_scr (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_fire && sel.is_scr),
        .wdata (new_val),
        .value (scr_q)
    );

    assign cycle_q   = cnt_q[CNT_CYCLE];
    assign time_q    = cnt_q[CNT_TIME];
    assign instret_q = cnt_q[CNT_INSTRET];

    assign rd_value   = rd_fire ? old_val : '0;
    assign read_done  = rd_fire;
    assign write_done = wr_fire;
    assign illegal    = bad;

endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk
    import csr_unit_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             inst_valid,
    input logic [6:0]       inst_opcode,
    input logic [2:0]       inst_funct3,
    input logic [4:0]       inst_rd,
    input logic [4:0]       inst_rs1,
    input logic [11:0]      inst_csr,
    input logic             timer_tick,
    input logic [31:0]      rd_value,
    input logic             read_done,
    input logic             write_done,
    input logic             illegal,
    input logic [CNT_W-1:0] cycle_q,
    input logic [CNT_W-1:0] time_q
);
    logic is_sys;
    logic in_map;
    assign is_sys = inst_valid && (inst_opcode == OPC_SYSTEM) && (inst_funct3[1:0] != 2'b00);
    assign in_map = (inst_csr == 12'h340) || (inst_csr >= 12'hC00 && inst_csr <= 12'hC02) ||
                    (inst_csr >= 12'hC80 && inst_csr <= 12'hC82) ||
                    (inst_csr == 12'hB02) || (inst_csr == 12'hB82);

    a_r1_not_csr_quiet: assert property (@(posedge clk) disable iff (rst)
        !is_sys |-> (!read_done && !write_done && !illegal && rd_value == 32'd0));

    a_r3_swap_x0_no_read: assert property (@(posedge clk) disable iff (rst)
        (is_sys && inst_funct3[1:0] == 2'b01 && inst_rd == 5'd0) |-> (!read_done && rd_value == 32'd0));

    a_r4_zero_field_no_write: assert property (@(posedge clk) disable iff (rst)
        (is_sys && inst_funct3[1] && inst_rs1 == 5'd0) |-> !write_done);

    a_r7_cycle_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cycle_q == $past(cycle_q) + 64'd1));

    a_r7_time_hold: assert property (@(posedge clk) disable iff (rst)
        !timer_tick |=> $stable(time_q));

    a_r10_unmapped_illegal: assert property (@(posedge clk) disable iff (rst)
        (is_sys && !in_map) |-> illegal);

    a_r10_illegal_exclusive: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!read_done && !write_done && rd_value == 32'd0));

endmodule

bind csr_unit csr_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .inst_valid  (inst_valid),
    .inst_opcode (inst_opcode),
    .inst_funct3 (inst_funct3),
    .inst_rd     (inst_rd),
    .inst_rs1    (inst_rs1),
    .inst_csr    (inst_csr),
    .timer_tick  (timer_tick),
    .rd_value    (rd_value),
    .read_done   (read_done),
    .write_done  (write_done),
    .illegal     (illegal),
    .cycle_q     (cycle_q),
    .time_q      (time_q)
);

// File: tb/csr_unit_bench.sv
module csr_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inst_valid = 1'b0;
    logic [6:0]  inst_opcode = 7'd0;
    logic [2:0]  inst_funct3 = 3'd0;
    logic [4:0]  inst_rd = 5'd0;
    logic [4:0]  inst_rs1 = 5'd0;
    logic [11:0] inst_csr = 12'd0;
    logic [31:0] rs1_value = 32'd0;
    logic        retire = 1'b0;
    logic        timer_tick = 1'b0;
    logic [31:0] rd_value;
    logic        read_done, write_done, illegal;

    int checks = 0;
    int errors = 0;
    logic [31:0] s_val;
    logic        s_rd, s_wr, s_ill;

    localparam logic [6:0] SYS = 7'b1110011;

    always #2 clk = ~clk;

    csr_unit u_csr_unit (
        .clk(clk), .rst(rst), .inst_valid(inst_valid), .inst_opcode(inst_opcode),
        .inst_funct3(inst_funct3), .inst_rd(inst_rd), .inst_rs1(inst_rs1),
        .inst_csr(inst_csr), .rs1_value(rs1_value), .retire(retire),
        .timer_tick(timer_tick), .rd_value(rd_value), .read_done(read_done),
        .write_done(write_done), .illegal(illegal)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, sample 1 ns later, let one posedge pass
    task automatic issue(input logic [6:0] opc, input logic [2:0] f3, input logic [4:0] rd,
                         input logic [4:0] rs1, input logic [11:0] adr, input logic [31:0] val,
                         input logic ret);
        inst_valid = 1'b1; inst_opcode = opc; inst_funct3 = f3; inst_rd = rd;
        inst_rs1 = rs1; inst_csr = adr; rs1_value = val; retire = ret;
        #1;
        s_val = rd_value; s_rd = read_done; s_wr = write_done; s_ill = illegal;
        @(negedge clk);
        inst_valid = 1'b0; retire = 1'b0; inst_opcode = 7'd0;
    endtask

    task automatic rd_csr(input logic [11:0] adr);
        issue(SYS, 3'b010, 5'd1, 5'd0, adr, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_reset();
        #1;
        chk(rd_value == 0 && !read_done && !write_done && !illegal, "R11 idle outputs", rd_value, 0);
        rd_csr(12'hC82);
        chk(s_val == 0 && s_rd && !s_ill, "R7 instret hi after reset", s_val, 0);
        rd_csr(12'hC01);
        chk(s_val == 0, "R7 time after reset", s_val, 0);
    endtask

    task automatic t_cycle();
        logic [31:0] a;
        rd_csr(12'hC00); a = s_val;
        repeat (10) @(negedge clk);
        rd_csr(12'hC00);
        chk(s_val - a == 32'd11, "R7 cycle advance", s_val - a, 11);
        rd_csr(12'hC80);
        chk(s_val == 0 && !s_ill, "R6 cycle high half", s_val, 0);
    endtask

    task automatic t_time();
        timer_tick = 1'b1;
        repeat (3) @(negedge clk);
        timer_tick = 1'b0;
        rd_csr(12'hC01);
        chk(s_val == 3, "R7 time ticks", s_val, 3);
    endtask

    task automatic t_instret();
        issue(SYS, 3'b001, 5'd5, 5'd1, 12'hB02, 32'd5, 1'b1);
        chk(s_val == 0 && s_rd && s_wr && !s_ill, "R2 instret old value", s_val, 0);
        rd_csr(12'hC02);
        chk(s_val == 5, "R8 low write wins over retire", s_val, 5);
        issue(SYS, 3'b001, 5'd5, 5'd1, 12'hB82, 32'd7, 1'b1);
        rd_csr(12'hC82);
        chk(s_val == 7, "R8 high write", s_val, 7);
        rd_csr(12'hC02);
        chk(s_val == 6, "R8 low sees own increment", s_val, 6);
        issue(SYS, 3'b001, 5'd0, 5'd1, 12'hB02, 32'hFFFF_FFFF, 1'b0);
        retire = 1'b1; @(negedge clk); retire = 1'b0;
        rd_csr(12'hC82);
        chk(s_val == 8, "R7 instret carry high", s_val, 8);
        rd_csr(12'hC02);
        chk(s_val == 0, "R7 instret carry low", s_val, 0);
    endtask

    task automatic t_scratch();
        issue(SYS, 3'b001, 5'd4, 5'd2, 12'h340, 32'hFFFF_FFFF, 1'b0);
        chk(s_val == 0 && s_wr, "R2 scratch old", s_val, 0);
        rd_csr(12'h340);
        chk(s_val == 32'hFFFF_00FF, "R5 scratch mask", s_val, 32'hFFFF_00FF);
        issue(SYS, 3'b111, 5'd4, 5'h0F, 12'h340, 32'h0, 1'b0);
        chk(s_val == 32'hFFFF_00FF && s_wr, "R2 clear imm old", s_val, 32'hFFFF_00FF);
        rd_csr(12'h340);
        chk(s_val == 32'hFFFF_00F0, "R5 clear imm bits", s_val, 32'hFFFF_00F0);
        issue(SYS, 3'b010, 5'd4, 5'd2, 12'h340, 32'h0000_0F0F, 1'b0);
        rd_csr(12'h340);
        chk(s_val == 32'hFFFF_00FF, "R5 set masked", s_val, 32'hFFFF_00FF);
        issue(SYS, 3'b010, 5'd4, 5'd0, 12'h340, 32'h0000_FFFF, 1'b0);
        chk(!s_wr && s_rd, "R4 set x0 no write", {31'd0, s_wr}, 0);
        issue(SYS, 3'b011, 5'd4, 5'd3, 12'h340, 32'h0, 1'b0);
        chk(s_wr, "R4 zero value still writes", {31'd0, s_wr}, 1);
        issue(SYS, 3'b110, 5'd4, 5'd0, 12'h340, 32'hFFFF_FFFF, 1'b0);
        chk(!s_wr, "R4 set imm zero no write", {31'd0, s_wr}, 0);
        rd_csr(12'h340);
        chk(s_val == 32'hFFFF_00FF, "R4 scratch unchanged", s_val, 32'hFFFF_00FF);
        issue(SYS, 3'b101, 5'd0, 5'h1F, 12'h340, 32'hDEAD_BEEF, 1'b0);
        chk(!s_rd && s_val == 0 && s_wr, "R3 swap imm x0 no read", s_val, 0);
        rd_csr(12'h340);
        chk(s_val == 32'h0000_001F, "R1 imm source", s_val, 32'h1F);
        issue(SYS, 3'b001, 5'd0, 5'd6, 12'h340, 32'h0000_0042, 1'b0);
        chk(!s_rd && s_wr, "R3 swap x0 no read", {30'd0, s_rd, s_wr}, 1);
    endtask

    task automatic t_illegal();
        issue(SYS, 3'b010, 5'd1, 5'd0, 12'hC00, 32'h0, 1'b0);
        chk(!s_ill && s_rd, "R9 ro read legal", {31'd0, s_ill}, 0);
        issue(SYS, 3'b111, 5'd1, 5'd0, 12'hC01, 32'h0, 1'b0);
        chk(!s_ill && !s_wr, "R9 ro clear zero imm legal", {31'd0, s_ill}, 0);
        issue(SYS, 3'b001, 5'd1, 5'd2, 12'hC02, 32'h55, 1'b0);
        chk(s_ill && !s_rd && !s_wr && s_val == 0, "R9 ro write illegal", {31'd0, s_ill}, 1);
        issue(SYS, 3'b010, 5'd1, 5'd0, 12'h123, 32'h0, 1'b0);
        chk(s_ill && !s_rd && s_val == 0, "R10 unmapped", {31'd0, s_ill}, 1);
        issue(SYS, 3'b001, 5'd1, 5'd2, 12'hB00, 32'h9, 1'b0);
        chk(s_ill, "R10 unmapped writable alias", {31'd0, s_ill}, 1);
        rd_csr(12'hC82);
        chk(s_val == 8, "R10 no state change", s_val, 8);
    endtask

    task automatic t_not_csr();
        issue(7'b0110011, 3'b001, 5'd1, 5'd2, 12'h340, 32'h1, 1'b0);
        chk(!s_rd && !s_wr && !s_ill && s_val == 0, "R1 other opcode", s_val, 0);
        issue(SYS, 3'b100, 5'd1, 5'd2, 12'h340, 32'h1, 1'b0);
        chk(!s_rd && !s_wr && !s_ill, "R1 funct3 100", {29'd0, s_rd, s_wr, s_ill}, 0);
        rd_csr(12'h340);
        chk(s_val == 32'h0000_0042, "R1 no state change", s_val, 32'h42);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cycle();
        t_time();
        t_instret();
        t_scratch();
        t_illegal();
        t_not_csr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule